// File: doc/BRIEF.md
# Regular-Sampled Triangle PWM Generator

This block drives one phase leg from a duty reference using a symmetric up/down triangle carrier. The comparison level is refreshed only at the carrier peaks, which are also the instants at which it raises a one-clock sample trigger. Current sampling, the controller update and the PWM level update therefore share one schedule. Between those instants the compare level is frozen, so the ripple that switching puts on the measured current never reaches the comparator.

A mode input selects the sampling schedule. Once-per-period sampling acts at the top of the carrier only. Twice-per-period sampling acts at both the top and the bottom, which doubles the sample rate for the same switching frequency. For example, a 5 kHz carrier gives a 10 kHz sample rate in that mode, and with a 100 MHz clock the half-period setting is 10000. The reference arrives through a shadow register. The output stage gives a complementary gate pair with a programmable blanking gap. A parameter can reduce it to a single gate.

Top module: `regsampled_pwm`

## Requirements
- R1: After reset the carrier output is 0. It rises by one per clock up to `halfPeriod`, then falls by one per clock to 0, and then rises again. One carrier period is 2·`halfPeriod` clocks, and `halfPeriod` must be at least 2.
- R2: The raw PWM level is high when the compare value is greater than the carrier value of the same cycle. With `deadCycles` = 0, `gateHi` shows the raw level one clock later and `gateLo` shows its inverse.
- R3: With `asymMode` = 0, `sampleTrig` is a single-clock pulse once per carrier period. It is high in the cycle right after the carrier was at `halfPeriod` while rising.
- R4: With `asymMode` = 1, `sampleTrig` also pulses in the cycle right after the carrier was at 0 while falling, so it pulses twice per carrier period.
- R5: A `refWrite` pulse stores `refIn` in a shadow register only, and the compare value does not change. The compare value takes the shadow contents at the clock edge that raises `sampleTrig`. A write on that same edge is kept for the next trigger.
- R6: A compare value of 0 keeps `gateHi` low for whole periods. A compare value at or above `halfPeriod` keeps `gateHi` high for whole periods.
- R7: When the raw level changes and `deadCycles` = N > 0, both gates are low for N clocks, starting one clock after the change. Then the gate for the new level turns on. A further change during the gap restarts the gap. `gateHi` and `gateLo` are never high together.
- R8: While `rstN` is low, `carrier`, `sampleTrig`, `gateHi` and `gateLo` are all 0, and the shadow and compare values are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| halfPeriod | input | CNT_W | Carrier peak value, in clocks per half period |
| asymMode | input | 1 | 0: sample at top peak only; 1: sample at top and bottom peaks |
| refIn | input | CNT_W | Duty reference value |
| refWrite | input | 1 | Stores refIn into the shadow register |
| deadCycles | input | DEAD_W | Blanking gap length in clocks |
| carrier | output | CNT_W | Current triangle carrier value |
| sampleTrig | output | 1 | One-clock sample pulse at the selected peaks |
| gateHi | output | 1 | Upper switch gate |
| gateLo | output | 1 | Lower switch gate (0 when the complementary output is disabled) |

## Verification
A cycle model of the carrier, shadow, compare and gap logic predicts every output in every cycle. The bench runs it with mid-range duties in both sampling modes, so that once-per-period and twice-per-period loading can be told apart by trigger counts over a two-period window. Zero duty and duty at or above the peak separate the forced-low and forced-high cases from ordinary comparison. The bench also writes the reference in every cycle, which catches a reference that leaks into the compare value between triggers or a write that collides with a trigger. Running with and without a gap, and with a smaller peak value, checks the blanking timing and the handling of a new period length.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
  typedef struct packed {
    logic load;
    logic atTop;
    logic atBottom;
  } ctrlStrobes_t;
endpackage

// File: rtl/pwm_carrier_ctrl.sv
module pwm_carrier_ctrl
  import pwm_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [CNT_W-1:0] halfPeriod,
  input  logic             asymMode,
  output ctrlStrobes_t     strobes,
  output logic [CNT_W-1:0] count
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] countQ;
  logic             upQ;
  logic             atTop;
  logic             atBottom;

  assign atTop    = upQ && (countQ >= halfPeriod);
  assign atBottom = !upQ && (countQ == '0);

  always_comb begin
    strobes.atTop    = atTop;
    strobes.atBottom = atBottom;
    strobes.load     = atTop || (asymMode && atBottom);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      countQ <= '0;
      upQ    <= 1'b1;
    end else if (atTop) begin
      countQ <= halfPeriod - ONE;
      upQ    <= 1'b0;
    end else if (atBottom) begin
      countQ <= ONE;
      upQ    <= 1'b1;
    end else if (upQ) begin
      countQ <= countQ + ONE;
    end else begin
      countQ <= countQ - ONE;
    end
  end

  assign count = countQ;

  // R1: carrier moves by exactly one step per clock while inside range
  assert_unit_step_R1: assert property (@(posedge clk) disable iff (!rstN)
    (countQ <= halfPeriod && halfPeriod >= CNT_W'(2)) ##1 $stable(halfPeriod) |->
      (countQ == $past(countQ) + ONE) || (countQ == $past(countQ) - ONE));
endmodule

// File: rtl/pwm_compare_path.sv
module pwm_compare_path
  import pwm_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctrlStrobes_t     strobes,
  input  logic [CNT_W-1:0] count,
  input  logic [CNT_W-1:0] halfPeriod,
  input  logic [CNT_W-1:0] refIn,
  input  logic             refWrite,
  output logic             pwmRaw,
  output logic             sampleTrig
);
  logic [CNT_W-1:0] shadowQ;
  logic [CNT_W-1:0] cmpQ;
  logic             trigQ;
  logic             forceHigh;
  logic             forceLow;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shadowQ <= '0;
    end else if (refWrite) begin
      shadowQ <= refIn;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmpQ  <= '0;
      trigQ <= 1'b0;
    end else begin
      trigQ <= strobes.load;
      if (strobes.load) cmpQ <= shadowQ;
    end
  end

  assign forceHigh  = (cmpQ >= halfPeriod);
  assign forceLow   = (cmpQ == '0);
  assign pwmRaw     = !forceLow && (forceHigh || (cmpQ > count));
  assign sampleTrig = trigQ;

  // R5: compare level frozen except at a load strobe
  assert_cmp_frozen_R5: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.load |=> $stable(cmpQ));

  // R3: trigger never lasts two cycles with a legal, steady peak value
  assert_trig_single_R3: assert property (@(posedge clk) disable iff (!rstN)
    (trigQ && halfPeriod >= CNT_W'(2) && $stable(halfPeriod)) |=> !trigQ);

  // R4: a trigger only follows a peak strobe
  assert_trig_at_peak_R4: assert property (@(posedge clk) disable iff (!rstN)
    !(strobes.atTop || strobes.atBottom) |=> !trigQ);
endmodule

// File: rtl/pwm_deadtime.sv
module pwm_deadtime #(
  parameter int DEAD_W        = 8,
  parameter bit COMPLEMENTARY = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              pwmRaw,
  input  logic [DEAD_W-1:0] deadCycles,
  output logic              gateHi,
  output logic              gateLo
);
  generate
    if (COMPLEMENTARY) begin : g_pair
      logic              prevQ;
      logic [DEAD_W-1:0] gapQ;
      logic              hiQ;
      logic              loQ;

      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          prevQ <= 1'b0;
          gapQ  <= '0;
          hiQ   <= 1'b0;
          loQ   <= 1'b0;
        end else if (pwmRaw != prevQ) begin
          prevQ <= pwmRaw;
          if (deadCycles == '0) begin
            hiQ  <= pwmRaw;
            loQ  <= !pwmRaw;
            gapQ <= '0;
          end else begin
            hiQ  <= 1'b0;
            loQ  <= 1'b0;
            gapQ <= deadCycles;
          end
        end else if (gapQ != '0) begin
          gapQ <= gapQ - DEAD_W'(1);
          if (gapQ == DEAD_W'(1)) begin
            hiQ <= prevQ;
            loQ <= !prevQ;
          end
        end else begin
          hiQ <= prevQ;
          loQ <= !prevQ;
        end
      end

      assign gateHi = hiQ;
      assign gateLo = loQ;

      // R7: with a gap set, no direct handoff from one switch to the other
      assert_gap_hi_R7: assert property (@(posedge clk) disable iff (!rstN)
        (deadCycles != '0 && $stable(deadCycles) && $rose(hiQ)) |-> !$past(loQ));
      assert_gap_lo_R7: assert property (@(posedge clk) disable iff (!rstN)
        (deadCycles != '0 && $stable(deadCycles) && $rose(loQ)) |-> !$past(hiQ));
    end else begin : g_single
      logic hiQ;
      logic unusedDead;
      assign unusedDead = ^deadCycles;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) hiQ <= 1'b0;
        else       hiQ <= pwmRaw;
      end
      assign gateHi = hiQ;
      assign gateLo = 1'b0;
    end
  endgenerate
endmodule

// File: rtl/regsampled_pwm.sv
module regsampled_pwm
  import pwm_pkg::*;
#(
  parameter int CNT_W         = 16,
  parameter int DEAD_W        = 8,
  parameter bit COMPLEMENTARY = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [CNT_W-1:0]  halfPeriod,
  input  logic              asymMode,
  input  logic [CNT_W-1:0]  refIn,
  input  logic              refWrite,
  input  logic [DEAD_W-1:0] deadCycles,
  output logic [CNT_W-1:0]  carrier,
  output logic              sampleTrig,
  output logic              gateHi,
  output logic              gateLo
);
  ctrlStrobes_t strobes;
  logic         pwmRaw;

  pwm_carrier_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .halfPeriod (halfPeriod),
    .asymMode   (asymMode),
    .strobes    (strobes),
    .count      (carrier)
  );

  pwm_compare_path #(.CNT_W(CNT_W)) u_path (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .count      (carrier),
    .halfPeriod (halfPeriod),
    .refIn      (refIn),
    .refWrite   (refWrite),
    .pwmRaw     (pwmRaw),
    .sampleTrig (sampleTrig)
  );

  pwm_deadtime #(.DEAD_W(DEAD_W), .COMPLEMENTARY(COMPLEMENTARY)) u_gap (
    .clk        (clk),
    .rstN       (rstN),
    .pwmRaw     (pwmRaw),
    .deadCycles (deadCycles),
    .gateHi     (gateHi),
    .gateLo     (gateLo)
  );
endmodule

// File: tb/tb_regsampled_pwm.sv
module tb_regsampled_pwm;
  localparam int CW = 16;
  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [CW-1:0] halfPeriod = 16'd8;
  logic          asymMode = 1'b0;
  logic [CW-1:0] refIn = '0;
  logic          refWrite = 1'b0;
  logic [DW-1:0] deadCycles = '0;
  logic [CW-1:0] carrier;
  logic          sampleTrig, gateHi, gateLo;

  always #4 clk = ~clk;

  regsampled_pwm dut (
    .clk(clk), .rstN(rstN), .halfPeriod(halfPeriod), .asymMode(asymMode),
    .refIn(refIn), .refWrite(refWrite), .deadCycles(deadCycles),
    .carrier(carrier), .sampleTrig(sampleTrig), .gateHi(gateHi), .gateLo(gateLo)
  );

  typedef struct {
    logic [CW-1:0] car;
    logic trig;
    logic hi;
    logic lo;
  } exp_t;

  exp_t expQ[$];
  int   errors = 0;
  int   checks = 0;
  int   trigSeen = 0;
  int   hiSeen = 0;
  int   cycles = 0;

  task automatic check(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, expv, $time);
    end
  endtask

  // Reference model built from the requirements; pushes the expected outputs per edge
  logic [CW-1:0] mCnt, mShadow, mCmp;
  logic          mUp, mTrig, mPrev, mHi, mLo;
  logic [DW-1:0] mGap;

  always @(posedge clk) begin
    if (!rstN) begin
      mCnt = '0; mUp = 1'b1; mShadow = '0; mCmp = '0; mTrig = 1'b0;
      mPrev = 1'b0; mHi = 1'b0; mLo = 1'b0; mGap = '0;
    end else begin
      logic top, bot, load, raw;
      top  = mUp && (mCnt >= halfPeriod);
      bot  = !mUp && (mCnt == '0);
      load = top || (asymMode && bot);
      raw  = (mCmp >= halfPeriod) ? 1'b1 : (mCmp > mCnt);
      if (mCmp == '0) raw = 1'b0;
      if (raw != mPrev) begin
        mPrev = raw;
        if (deadCycles == '0) begin mHi = raw; mLo = !raw; mGap = '0; end
        else begin mHi = 1'b0; mLo = 1'b0; mGap = deadCycles; end
      end else if (mGap != '0) begin
        if (mGap == 1) begin mHi = mPrev; mLo = !mPrev; end
        mGap = mGap - 1'b1;
      end else begin
        mHi = mPrev; mLo = !mPrev;
      end
      mTrig = load;
      if (load) mCmp = mShadow;
      if (refWrite) mShadow = refIn;
      if (top) begin mCnt = halfPeriod - 1'b1; mUp = 1'b0; end
      else if (bot) begin mCnt = 16'd1; mUp = 1'b1; end
      else if (mUp) mCnt = mCnt + 1'b1;
      else mCnt = mCnt - 1'b1;
    end
    expQ.push_back('{car: mCnt, trig: mTrig, hi: mHi, lo: mLo});
  end

  // Monitor: pops expected items and compares them away from the active edge
  always @(negedge clk) begin
    if (expQ.size() > 0) begin
      exp_t e;
      e = expQ.pop_front();
      check(carrier == e.car, "R1 carrier", int'(carrier), int'(e.car));
      check(sampleTrig == e.trig, asymMode ? "R4 sampleTrig" : "R3 sampleTrig",
            int'(sampleTrig), int'(e.trig));
      check(gateHi == e.hi, "R2/R5/R7 gateHi", int'(gateHi), int'(e.hi));
      check(gateLo == e.lo, "R2/R7 gateLo", int'(gateLo), int'(e.lo));
      check(!(gateHi && gateLo), "R7 overlap", int'(gateLo), 0);
      if (sampleTrig) trigSeen++;
      if (gateHi) hiSeen++;
    end
  end

  task automatic finishRun();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
      finishRun();
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic writeRef(input logic [CW-1:0] v);
    @(negedge clk);
    refIn = v; refWrite = 1'b1;
    @(negedge clk);
    refWrite = 1'b0;
  endtask

  task automatic countWindow(input int n, output int trigs, output int his);
    int t0, h0;
    @(negedge clk); #1;
    t0 = trigSeen; h0 = hiSeen;
    repeat (n) @(negedge clk);
    #1;
    trigs = trigSeen - t0;
    his   = hiSeen - h0;
  endtask

  initial begin
    int tr, hs;
    idle(3);
    #1;
    // R8: reset state at the ports
    check(carrier == '0, "R8 carrier in reset", int'(carrier), 0);
    check(sampleTrig == 1'b0, "R8 trig in reset", int'(sampleTrig), 0);
    check(gateHi == 1'b0 && gateLo == 1'b0, "R8 gates in reset", int'({gateHi, gateLo}), 0);
    @(negedge clk);
    rstN = 1'b1;

    // R2, R3: mid duty, once-per-period sampling
    writeRef(16'd3);
    idle(40);
    countWindow(32, tr, hs);
    check(tr == 2, "R3 triggers per two periods", tr, 2);

    // R4: twice-per-period sampling
    asymMode = 1'b1;
    idle(20);
    countWindow(32, tr, hs);
    check(tr == 4, "R4 triggers per two periods", tr, 4);

    // R7: blanking gap with a different duty
    deadCycles = 8'd2;
    writeRef(16'd5);
    idle(60);

    // R6: zero duty stays low
    writeRef(16'd0);
    idle(40);
    countWindow(32, tr, hs);
    check(hs == 0, "R6 zero duty high cycles", hs, 0);

    // R6: duty at and above the peak stays high
    writeRef(16'd8);
    idle(40);
    countWindow(32, tr, hs);
    check(hs == 32, "R6 peak duty high cycles", hs, 32);
    writeRef(16'd12);
    idle(40);
    countWindow(32, tr, hs);
    check(hs == 32, "R6 above-peak duty high cycles", hs, 32);

    // R5: a write in every cycle, including ones that meet a trigger
    for (int i = 0; i < 48; i++) begin
      @(negedge clk);
      refIn = 16'((i * 3) % 10);
      refWrite = 1'b1;
    end
    @(negedge clk);
    refWrite = 1'b0;
    idle(40);

    // R1: smaller peak, single sampling, no gap
    asymMode = 1'b0;
    deadCycles = '0;
    halfPeriod = 16'd5;
    writeRef(16'd2);
    idle(50);
    countWindow(20, tr, hs);
    check(tr == 2, "R1/R3 triggers with peak 5", tr, 2);

    idle(2);
    finishRun();
  end
endmodule